// File: doc/BRIEF.md
# Event Fragmenting Packetizer

This block turns a stream of detector events into frames sized for a single UDP payload. An event arrives as a sequence of 32-bit data words on a valid/ready input, and the final word is marked with a last flag. The block wraps the words in one or more frames. Every frame opens with three prefix words: a running frame number, a data header and a header-info word. The data words follow. Only the last frame of an event closes with a trailer word, and that word reports how many data words the event held.

When an event has more data words than one frame may carry, the block ends the current frame at the payload limit and starts a new one. The new frame gets the next frame number and the same header and info words. With the frame number, a receiver can put fragments back in order and spot a lost fragment. The header and info values come from side-band inputs. They are captured when the first beat of an event is presented, so the source may change them freely once the event has begun.

Zero-length events are signalled by a single beat with both the void flag and the last flag set. Output words carry their own last flag, which marks the end of every frame. Backpressure on the output stalls the input without loss or duplication.

Top module: `evt_frag_packer`

## Requirements
- R1: After reset, out_valid_o and in_ready_o are low, and the first frame ever emitted carries frame number 0.
- R2: Each frame begins with three prefix words in this fixed order: the frame number (zero-extended to DATA_W), the captured header word, then the captured info word. Data words follow in arrival order.
- R3: A frame carries at most MAX_PAYLOAD data words. An event longer than that continues in further frames. If an event's length is an exact multiple of MAX_PAYLOAD, the trailer follows the last data word in the same frame, and no empty frame is added.
- R4: The frame number increments by one for each emitted frame, continues across events, and wraps modulo 2^CNT_W.
- R5: hdr_i and info_i are sampled in the cycle when the first beat of an event is presented while the block is idle. Every frame of that event repeats these sampled values, and later changes to the inputs have no effect until the next event.
- R6: The trailer word carries TAIL_MARK (default 16'hE7E0) in bits [31:16] and the event's data word count modulo 2^16 in bits [15:0]. It appears only once, right after the final data word of the final frame.
- R7: A beat with in_void_i=1 and in_last_i=1 ends the event without a data word. An event made of only such a beat produces one frame: the three prefix words and then the trailer, with count 0.
- R8: out_last_o is high on the final word of every frame and low on every other word.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_last_o stay unchanged on the next cycle. No input word is lost or duplicated under backpressure.
- R10: in_ready_o is low while the three prefix words and the trailer are being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Event data word |
| in_valid_i | input | 1 | Input beat valid |
| in_last_i | input | 1 | Beat closes the event |
| in_void_i | input | 1 | Beat carries no data word (used with in_last_i) |
| in_ready_o | output | 1 | Input beat accepted when high with in_valid_i |
| hdr_i | input | DATA_W | Data header value for the next event |
| info_i | input | DATA_W | Header-info value for the next event |
| out_data_o | output | DATA_W | Frame word |
| out_valid_o | output | 1 | Output word valid |
| out_last_o | output | 1 | Word closes the frame |
| out_ready_i | input | 1 | Downstream accepts the word |

## Verification
The bench builds the block with MAX_PAYLOAD=4 and CNT_W=3. With a payload of only four words, events of three, four, six and nine words fall below, exactly on and across frame boundaries within a few dozen cycles. A three-bit frame number wraps after eight frames, so the modulo behaviour is reached in a short run. The random output stall pattern and the header change made in the middle of an event exercise backpressure and header capture under these small sizes.

// File: rtl/evt_frag_pkg.sv
package evt_frag_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_HDR,
    ST_INFO,
    ST_BODY,
    ST_TAIL
  } frag_st_e;

  localparam int unsigned TAIL_CNT_W = 16;

endpackage

// File: rtl/evt_frag_seq.sv
module evt_frag_seq
  import evt_frag_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned MAX_PAYLOAD = 2240
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic                  in_last_i,
  input  logic                  in_void_i,
  input  logic                  in_take_i,
  input  logic                  out_take_i,
  input  logic [DATA_W-1:0]     hdr_i,
  input  logic [DATA_W-1:0]     info_i,
  output frag_st_e              state_o,
  output logic                  cap_o,
  output logic [TAIL_CNT_W-1:0] evt_cnt_o,
  output logic [DATA_W-1:0]     hdr_o,
  output logic [DATA_W-1:0]     info_o
);

  localparam int unsigned PAY_W = $clog2(MAX_PAYLOAD + 1);
  localparam logic [PAY_W-1:0] PAY_LAST = PAY_W'(MAX_PAYLOAD - 1);

  frag_st_e              state_q, state_d;
  logic [PAY_W-1:0]      pay_q;
  logic [TAIL_CNT_W-1:0] evt_q;
  logic [DATA_W-1:0]     hdr_q, info_q;
  logic                  data_take;

  assign data_take = in_take_i && !in_void_i;
  assign cap_o     = (pay_q == PAY_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid_i) state_d = ST_CNT;
      ST_CNT:  if (out_take_i) state_d = ST_HDR;
      ST_HDR:  if (out_take_i) state_d = ST_INFO;
      ST_INFO: if (out_take_i) state_d = ST_BODY;
      ST_BODY: begin
        if (in_take_i) begin
          if (in_last_i)              state_d = ST_TAIL;
          else if (data_take && cap_o) state_d = ST_CNT; // payload full, open next frame
        end
      end
      ST_TAIL: if (out_take_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pay_q   <= '0;
      evt_q   <= '0;
      hdr_q   <= '0;
      info_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        evt_q <= '0;
        if (in_valid_i) begin
          hdr_q  <= hdr_i;
          info_q <= info_i;
        end
      end
      if (state_q == ST_CNT) pay_q <= '0;
      if (state_q == ST_BODY && data_take) begin
        pay_q <= pay_q + 1'b1;
        evt_q <= evt_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign evt_cnt_o = evt_q;
  assign hdr_o     = hdr_q;
  assign info_o    = info_q;

endmodule

// File: rtl/evt_frag_frame_ctr.sv
module evt_frag_frame_ctr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  output logic [DATA_W-1:0] fc_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (frame_end_i) cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (CNT_W >= DATA_W) begin : g_full
      assign fc_o = cnt_q[DATA_W-1:0];
    end else begin : g_pad
      assign fc_o = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
    end
  endgenerate

endmodule

// File: rtl/evt_frag_out_mux.sv
module evt_frag_out_mux
  import evt_frag_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-TAIL_CNT_W-1:0] TAIL_MARK = 'hE7E0
) (
  input  frag_st_e              state_i,
  input  logic                  cap_i,
  input  logic [TAIL_CNT_W-1:0] evt_cnt_i,
  input  logic [DATA_W-1:0]     fc_i,
  input  logic [DATA_W-1:0]     hdr_i,
  input  logic [DATA_W-1:0]     info_i,
  input  logic [DATA_W-1:0]     in_data_i,
  input  logic                  in_valid_i,
  input  logic                  in_last_i,
  input  logic                  in_void_i,
  input  logic                  out_ready_i,
  output logic [DATA_W-1:0]     out_data_o,
  output logic                  out_valid_o,
  output logic                  out_last_o,
  output logic                  in_ready_o
);

  always_comb begin
    out_data_o  = '0;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    unique case (state_i)
      ST_CNT: begin
        out_data_o  = fc_i;
        out_valid_o = 1'b1;
      end
      ST_HDR: begin
        out_data_o  = hdr_i;
        out_valid_o = 1'b1;
      end
      ST_INFO: begin
        out_data_o  = info_i;
        out_valid_o = 1'b1;
      end
      ST_BODY: begin
        out_data_o  = in_data_i;
        out_valid_o = in_valid_i && !in_void_i;
        out_last_o  = !in_void_i && !in_last_i && cap_i;
        in_ready_o  = in_void_i ? 1'b1 : out_ready_i; // void beats are dropped
      end
      ST_TAIL: begin
        out_data_o  = {TAIL_MARK, evt_cnt_i};
        out_valid_o = 1'b1;
        out_last_o  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/evt_frag_packer.sv
module evt_frag_packer
  import evt_frag_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned MAX_PAYLOAD = 2240,
  parameter int unsigned CNT_W       = 32,
  parameter logic [DATA_W-TAIL_CNT_W-1:0] TAIL_MARK = 'hE7E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic              in_void_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] hdr_i,
  input  logic [DATA_W-1:0] info_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);

  frag_st_e              state;
  logic                  cap;
  logic [TAIL_CNT_W-1:0] evt_cnt;
  logic [DATA_W-1:0]     hdr_q, info_q, fc;
  logic                  in_take, out_take;

  assign in_take  = in_valid_i && in_ready_o;
  assign out_take = out_valid_o && out_ready_i;

  evt_frag_seq #(
    .DATA_W      (DATA_W),
    .MAX_PAYLOAD (MAX_PAYLOAD)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_void_i  (in_void_i),
    .in_take_i  (in_take),
    .out_take_i (out_take),
    .hdr_i      (hdr_i),
    .info_i     (info_i),
    .state_o    (state),
    .cap_o      (cap),
    .evt_cnt_o  (evt_cnt),
    .hdr_o      (hdr_q),
    .info_o     (info_q)
  );

  evt_frag_frame_ctr #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_fctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (out_take && out_last_o),
    .fc_o        (fc)
  );

  evt_frag_out_mux #(
    .DATA_W    (DATA_W),
    .TAIL_MARK (TAIL_MARK)
  ) u_mux (
    .state_i     (state),
    .cap_i       (cap),
    .evt_cnt_i   (evt_cnt),
    .fc_i        (fc),
    .hdr_i       (hdr_q),
    .info_i      (info_q),
    .in_data_i   (in_data_i),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .in_void_i   (in_void_i),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .in_ready_o  (in_ready_o)
  );

endmodule

// File: rtl/evt_frag_packer_chk.sv
module evt_frag_packer_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned MAX_PAYLOAD = 2240,
  parameter int unsigned CNT_W       = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              out_last_o,
  input logic              out_ready_i
);

  localparam int unsigned POS_W = $clog2(MAX_PAYLOAD + 5);
  localparam logic [POS_W-1:0] POS_HDR = POS_W'(3);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(MAX_PAYLOAD + 3);

  logic [POS_W-1:0]  pos_q;
  logic [CNT_W-1:0]  fc_q;
  logic [DATA_W-1:0] fc_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fc_q  <= '0;
    end else if (out_valid_o && out_ready_i) begin
      if (out_last_o) begin
        pos_q <= '0;
        fc_q  <= fc_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  generate
    if (CNT_W >= DATA_W) begin : g_full
      assign fc_ext = fc_q[DATA_W-1:0];
    end else begin : g_pad
      assign fc_ext = {{(DATA_W-CNT_W){1'b0}}, fc_q};
    end
  endgenerate

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  a_r10_no_take_in_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < POS_HDR |-> !in_ready_o);

  a_r3_payload_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pos_q <= POS_MAX);

  a_r8_prefix_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q < POS_HDR |-> !out_last_o);

  a_r4_frame_number: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q == '0 |-> out_data_o == fc_ext);

endmodule

bind evt_frag_packer evt_frag_packer_chk #(
  .DATA_W      (DATA_W),
  .MAX_PAYLOAD (MAX_PAYLOAD),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/evt_frag_packer_tb.sv
module evt_frag_packer_tb;

  localparam int TCLK = 10;
  localparam int DW   = 32;
  localparam int MAXP = 4;
  localparam int CW   = 3;
  localparam logic [15:0] MARK = 16'hE7E0;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_valid_i = 1'b0, in_last_i = 1'b0, in_void_i = 1'b0;
  logic          in_ready_o;
  logic [DW-1:0] hdr_i = '0, info_i = '0;
  logic [DW-1:0] out_data_o;
  logic          out_valid_o, out_last_o;
  logic          out_ready_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  int fc_model = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [DW-1:0] cap_d[$], exp_d[$];
  logic          cap_l[$], exp_l[$];
  int pos_mon = 0;
  int r10_bad = 0, r9_bad = 0;
  logic          prev_stall = 1'b0;
  logic [DW-1:0] prev_d = '0;
  logic          prev_l = 1'b0;

  always #(TCLK/2) clk_i = ~clk_i;

  evt_frag_packer #(.DATA_W(DW), .MAX_PAYLOAD(MAXP), .CNT_W(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .in_void_i(in_void_i), .in_ready_o(in_ready_o),
    .hdr_i(hdr_i), .info_i(info_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
    .out_ready_i(out_ready_i));

  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pos_mon < 3 && in_ready_o) r10_bad++;
      if (prev_stall && !(out_valid_o && out_data_o == prev_d && out_last_o == prev_l)) r9_bad++;
      prev_stall = out_valid_o && !out_ready_i;
      prev_d = out_data_o;
      prev_l = out_last_o;
      if (out_valid_o && out_ready_i) begin
        cap_d.push_back(out_data_o);
        cap_l.push_back(out_last_o);
        pos_mon = out_last_o ? 0 : pos_mon + 1;
      end
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(logic [DW-1:0] d, logic l);
    exp_d.push_back(d);
    exp_l.push_back(l);
  endtask

  task automatic model_event(int n, logic [DW-1:0] base, logic [DW-1:0] h, logic [DW-1:0] inf);
    int rem = n;
    int i = 0;
    forever begin
      push_exp(DW'(fc_model), 1'b0);
      fc_model = (fc_model + 1) % (1 << CW);
      push_exp(h, 1'b0);
      push_exp(inf, 1'b0);
      for (int k = 0; k < MAXP && rem > 0; k++) begin
        rem--;
        push_exp(base + DW'(i), (k == MAXP-1) && rem > 0);
        i++;
      end
      if (rem == 0) break;
    end
    push_exp({MARK, 16'(n)}, 1'b1);
  endtask

  task automatic beat(logic [DW-1:0] d, logic l, logic v);
    in_data_i = d; in_last_i = l; in_void_i = v; in_valid_i = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk_i);
      if (in_ready_o) break;
    end
    @(posedge clk_i); #1;
    in_valid_i = 1'b0; in_last_i = 1'b0; in_void_i = 1'b0;
  endtask

  task automatic send_event(int n, logic [DW-1:0] base, bit swap_hdr, bit gaps);
    if (n == 0) beat('0, 1'b1, 1'b1);
    for (int i = 0; i < n; i++) begin
      beat(base + DW'(i), i == n-1, 1'b0);
      if (swap_hdr && i == 0) begin
        hdr_i = ~hdr_i; info_i = ~info_i;
      end
      if (gaps && i[0]) begin
        @(posedge clk_i); #1;
      end
    end
  endtask

  task automatic flush(string tag);
    for (int t = 0; t < 3000 && cap_d.size() < exp_d.size(); t++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check({tag, " word count"}, DW'(cap_d.size()), DW'(exp_d.size()));
    for (int i = 0; i < exp_d.size() && i < cap_d.size(); i++) begin
      check($sformatf("%s data[%0d]", tag, i), cap_d[i], exp_d[i]);
      check($sformatf("%s R8 last[%0d]", tag, i), DW'(cap_l[i]), DW'(exp_l[i]));
    end
    cap_d.delete(); cap_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  task automatic run_event(string tag, int n, logic [DW-1:0] base, bit swap, bit gaps);
    model_event(n, base, hdr_i, info_i);
    send_event(n, base, swap, gaps);
    flush(tag);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 out_valid after reset", DW'(out_valid_o), 0);
    check("R1 in_ready after reset", DW'(in_ready_o), 0);
  endtask

  task automatic t_short();
    hdr_i = 32'h1111_0001; info_i = 32'h2222_0001;
    run_event("R1 R2 R6 short event", 3, 32'hA000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_exact();
    hdr_i = 32'h1111_0002; info_i = 32'h2222_0002;
    run_event("R3 exact payload", MAXP, 32'hB000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_split();
    hdr_i = 32'h1111_0003; info_i = 32'h2222_0003;
    run_event("R3 R4 split event", 9, 32'hC000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_empty();
    hdr_i = 32'h1111_0004; info_i = 32'h2222_0004;
    run_event("R7 empty event", 0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_backpressure();
    r9_bad = 0;
    bp_on = 1'b1;
    hdr_i = 32'h1111_0005; info_i = 32'h2222_0005;
    // R5: header inputs inverted after the first beat must not appear
    run_event("R5 R9 stalled event", 6, 32'hD000_0000, 1'b1, 1'b1);
    bp_on = 1'b0;
    check("R9 stall hold violations", DW'(r9_bad), 0);
  endtask

  task automatic t_wrap();
    hdr_i = 32'h1111_0006; info_i = 32'h2222_0006;
    for (int e = 0; e < 3; e++) run_event("R4 wrap", e + 1, 32'hE000_0000 + DW'(e << 8), 1'b0, 1'b0);
    check("R10 in_ready during prefix", DW'(r10_bad), 0);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    @(posedge clk_i); #1;
    t_short();
    t_exact();
    t_split();
    t_empty();
    t_backpressure();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule